// File: doc/BRIEF.md
# Link Packet Receive Filter

The block sits between a simplified physical-layer receive interface and a general-receive FIFO. It takes one 32-bit quadlet per valid cycle, with a start marker on the first quadlet of each packet. From the first quadlet it decides whether the packet belongs to this node: unicast to the node's own ID, broadcast, an isochronous channel that is enabled, or a cycle-start packet. Anything else is skipped.

For an accepted packet, the header quadlets go into the FIFO tentatively. They become visible to the FIFO reader only when the header CRC quadlet matches. A bad header CRC rewinds the write pointer, and the rest of the packet is dropped. Payload quadlets are committed one at a time as they arrive. Once the payload ends, a status quadlet is appended. It carries the acknowledge code the link returns, or would return for traffic that is never acknowledged, so the consumer learns whether the payload CRC was good.

Cycle-start packets never touch the FIFO. Their second quadlet is presented on a cycle-time output. The FIFO storage sits outside the block; the block drives its write port and publishes the committed write pointer, and the reader returns its read pointer.

Top module: `lpr_filter`

## Requirements
- R1: First quadlet fields are destination [31:26], channel [25:20], payload length in quadlets [15:8] and packet type [3:0]. Types 0x0 (header only) and 0x1 (block) are accepted when the destination equals `node_id` or is all ones. Type 0xA (isochronous) is accepted when `chan_en[channel]` is set. Type 0x8 is cycle-start. Every other packet is skipped with no FIFO write and no acknowledge.
- R2: Every packet has 2 header quadlets followed by a header CRC quadlet. For accepted packets the header quadlets are written to the FIFO but become committed only on the cycle the header CRC quadlet matches.
- R3: On a header CRC mismatch the uncommitted header quadlets are discarded, the following quadlets of that packet are ignored and no acknowledge is produced.
- R4: Block and isochronous packets with nonzero length carry that many payload quadlets, then a payload CRC quadlet. Each payload quadlet is committed on the cycle it is written. The payload CRC quadlet is not stored.
- R5: After the last header quadlet (zero payload) or after the payload CRC quadlet, one status quadlet is written and committed: bits [7:4] hold the packet type, bits [3:0] the code, all other bits zero.
- R6: Codes are 0x1 complete, 0xD payload CRC error and 0x4 busy. Each code is also reported once on `ack_valid`/`ack_code`. `ack_send` is 1 only for type 0x0/0x1 packets unicast to the node, and 0 for broadcast and isochronous packets.
- R7: A cycle-start packet with a good header CRC pulses `cyc_valid` for one cycle with `cyc_time` equal to its second quadlet, and writes nothing to the FIFO.
- R8: If 2 + payload length + 1 exceeds the free FIFO space, the packet is not written and code 0x4 is reported. A packet that exactly fills the FIFO is accepted.
- R9: A start marker arriving before the header CRC quadlet abandons the current packet, discards its uncommitted header and starts the new packet.
- R10: Both CRCs are the 32-bit polynomial 0x04C11DB7, preset all ones, processed most significant bit first over whole quadlets, with no reflection or final inversion. They are computed separately over the header quadlets and over the payload quadlets.
- R11: FIFO writes, acknowledges and the cycle-start pulse appear one cycle after the quadlet that causes them. `fifo_commit_ptr` reflects a confirmation two cycles after that quadlet.
- R12: Once reset is released, no write, acknowledge or cycle pulse is active and the committed pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 6 | This node's bus address |
| chan_en | input | 64 | Enabled isochronous channels, one bit per channel |
| in_valid | input | 1 | Receive quadlet valid |
| in_sop | input | 1 | Quadlet is the first of a packet |
| in_data | input | 32 | Receive quadlet |
| fifo_rd_ptr | input | 6 | FIFO read pointer, with a wrap bit |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_waddr | output | 5 | FIFO write address |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_commit_ptr | output | 6 | Committed write pointer, with a wrap bit |
| ack_valid | output | 1 | Acknowledge code valid |
| ack_code | output | 4 | Acknowledge or status code |
| ack_send | output | 1 | Code must go back on the bus |
| cyc_valid | output | 1 | Cycle-start data valid |
| cyc_time | output | 32 | Cycle-start data quadlet |

## Verification
Each FIFO write, acknowledge and cycle pulse is due exactly one cycle after the quadlet that causes it. The committed pointer moves one cycle after the write it covers, so the bench model's storage always holds a quadlet before the reader can see it.

The bench drives every quadlet just after a falling edge. It checks the cycle-start pulse on the falling edge that follows the header CRC quadlet, so a late or early pulse is caught. The monitor samples on every falling edge, reads the storage model only up to the committed pointer, and compares acknowledges and committed quadlets in order against queues filled from the requirements. Anything flushed, skipped or diverted therefore shows up as an unexpected item or a wrong value.

// File: rtl/lpr_pkg.sv
`timescale 1ns/1ps
package lpr_pkg;
  localparam int QW = 32;

  localparam logic [3:0] TC_HDRONLY = 4'h0;
  localparam logic [3:0] TC_BLOCK   = 4'h1;
  localparam logic [3:0] TC_CYCST   = 4'h8;
  localparam logic [3:0] TC_ISO     = 4'hA;

  localparam logic [3:0] CODE_DONE  = 4'h1;
  localparam logic [3:0] CODE_BUSY  = 4'h4;
  localparam logic [3:0] CODE_DERR  = 4'hD;

  localparam logic [QW-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [QW-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_SKIP, ST_HDR, ST_HCRC, ST_PAY, ST_DCRC
  } rx_state_e;

  // one quadlet through the CRC register, most significant bit first
  function automatic logic [QW-1:0] crc_step(input logic [QW-1:0] cur,
                                             input logic [QW-1:0] din);
    logic [QW-1:0] r;
    r = cur;
    for (int i = QW - 1; i >= 0; i--) begin
      if (r[QW-1] ^ din[i]) r = {r[QW-2:0], 1'b0} ^ CRC_POLY;
      else                  r = {r[QW-2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [QW-1:0] status_word(input logic [3:0] tc,
                                                input logic [3:0] code);
    return {{(QW-8){1'b0}}, tc, code};
  endfunction
endpackage

// File: rtl/lpr_addr_match.sv
`timescale 1ns/1ps
module lpr_addr_match
  import lpr_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int CHAN_W = 6,
  parameter int LEN_W  = 8
) (
  input  logic [NODE_W-1:0]       dest,
  input  logic [CHAN_W-1:0]       chan,
  input  logic [3:0]              tcode,
  input  logic [LEN_W-1:0]        len,
  input  logic [NODE_W-1:0]       node_id,
  input  logic [(1<<CHAN_W)-1:0]  chan_en,
  output logic                    accept,
  output logic                    is_cycst,
  output logic                    ack_send,
  output logic                    has_pay
);
  logic is_async;
  logic is_iso;
  logic bcast;
  logic uni;

  always_comb begin
    is_async = (tcode == TC_HDRONLY) || (tcode == TC_BLOCK);
    is_iso   = (tcode == TC_ISO);
    bcast    = &dest;
    uni      = (dest == node_id) && !bcast;
    accept   = (is_async && (uni || bcast)) || (is_iso && chan_en[chan]);
    is_cycst = (tcode == TC_CYCST);
    ack_send = is_async && uni;
    has_pay  = ((tcode == TC_BLOCK) || is_iso) && (len != '0);
  end
endmodule

// File: rtl/lpr_crc_acc.sv
`timescale 1ns/1ps
module lpr_crc_acc
  import lpr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed,
  input  logic          start,
  input  logic          upd,
  input  logic [QW-1:0] din,
  output logic [QW-1:0] crc
);
  logic [QW-1:0] crc_q;
  logic [QW-1:0] crc_d;
  logic          crc_en;

  always_comb begin
    crc_en = seed | start | upd;
    crc_d  = crc_q;
    if (start)     crc_d = crc_step(CRC_SEED, din);
    else if (upd)  crc_d = crc_step(crc_q, din);
    else if (seed) crc_d = CRC_SEED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/lpr_wr_ptr.sv
`timescale 1ns/1ps
module lpr_wr_ptr #(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        confirm,
  input  logic        flush,
  input  logic [AW:0] rd_ptr,
  output logic [AW-1:0] waddr,
  output logic [AW:0] commit,
  output logic [AW:0] free
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0] tent_q, tent_d, tent_base;
  logic [AW:0] commit_q, commit_d;
  logic [AW:0] used;

  always_comb begin
    tent_base = flush ? commit_q : tent_q;
    tent_d    = tent_base + {{AW{1'b0}}, we};
    commit_d  = confirm ? tent_d : commit_q;
    used      = commit_q - rd_ptr;
    free      = DEPTH_V - used;
    waddr     = tent_base[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tent_q   <= '0;
      commit_q <= '0;
    end else begin
      if (we || flush) tent_q   <= tent_d;
      if (confirm)     commit_q <= commit_d;
    end
  end

  assign commit = commit_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tent_q - rd_ptr) <= DEPTH_V); // R8
  AST_FLUSH_NOT_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush && confirm)); // R3
endmodule

// File: rtl/lpr_filter.sv
`timescale 1ns/1ps
module lpr_filter
  import lpr_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int CHAN_W = 6,
  parameter int LEN_W  = 8,
  parameter int AW     = 5,
  parameter int HDR_Q  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NODE_W-1:0]      node_id,
  input  logic [(1<<CHAN_W)-1:0] chan_en,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic [QW-1:0]          in_data,
  input  logic [AW:0]            fifo_rd_ptr,
  output logic                   fifo_we,
  output logic [AW-1:0]          fifo_waddr,
  output logic [QW-1:0]          fifo_wdata,
  output logic [AW:0]            fifo_commit_ptr,
  output logic                   ack_valid,
  output logic [3:0]             ack_code,
  output logic                   ack_send,
  output logic                   cyc_valid,
  output logic [QW-1:0]          cyc_time
);
  localparam int DST_LO = QW - NODE_W;
  localparam int CH_LO  = DST_LO - CHAN_W;
  localparam int LEN_LO = 8;
  localparam int NW     = ((LEN_W > AW) ? LEN_W : AW) + 2;
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_Q - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  logic srst_n;
  assign srst_n = rst_s_q;

  // first-quadlet decode
  logic am_accept, am_cycst, am_send, am_haspay;
  lpr_addr_match #(.NODE_W(NODE_W), .CHAN_W(CHAN_W), .LEN_W(LEN_W)) u_match (
    .dest     (in_data[QW-1:DST_LO]),
    .chan     (in_data[DST_LO-1:CH_LO]),
    .tcode    (in_data[3:0]),
    .len      (in_data[LEN_LO+LEN_W-1:LEN_LO]),
    .node_id  (node_id),
    .chan_en  (chan_en),
    .accept   (am_accept),
    .is_cycst (am_cycst),
    .ack_send (am_send),
    .has_pay  (am_haspay)
  );

  // state
  rx_state_e        st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [3:0]       tc_q;
  logic             store_q, send_q, haspay_q, pend_q, pend_d;
  logic [LEN_W-1:0] len_q;
  logic [QW-1:0]    cyc_hold_q;

  // per-cycle controls
  logic             hdr_load, cap_cyc;
  logic             we_d, confirm, flush;
  logic [QW-1:0]    wdata_d;
  logic             ack_v_d, ack_s_d, cyc_v_d;
  logic [3:0]       ack_c_d;
  logic             crc_seed, crc_start, crc_upd;
  logic [QW-1:0]    crc_cur;
  logic [NW-1:0]    need;
  logic [AW:0]      ptr_free;
  logic [AW-1:0]    ptr_waddr;
  logic [AW:0]      ptr_commit;
  logic [3:0]       dcode;

  // output registers
  logic             we_q, ack_v_q, ack_s_q, cyc_v_q;
  logic [AW-1:0]    waddr_q;
  logic [QW-1:0]    wdata_q, cyc_time_q;
  logic [3:0]       ack_c_q;
  logic [AW:0]      commit_out_q;

  lpr_crc_acc u_crc (
    .clk   (clk),
    .rst_n (srst_n),
    .seed  (crc_seed),
    .start (crc_start),
    .upd   (crc_upd),
    .din   (in_data),
    .crc   (crc_cur)
  );

  lpr_wr_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst_n   (srst_n),
    .we      (we_d),
    .confirm (confirm),
    .flush   (flush),
    .rd_ptr  (fifo_rd_ptr),
    .waddr   (ptr_waddr),
    .commit  (ptr_commit),
    .free    (ptr_free)
  );

  always_comb begin
    need = NW'(HDR_Q) + NW'(1)
         + (am_haspay ? NW'(in_data[LEN_LO+LEN_W-1:LEN_LO]) : NW'(0));
    dcode = (in_data == crc_cur) ? CODE_DONE : CODE_DERR;
  end

  // next-state process
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    pend_d    = pend_q;
    hdr_load  = 1'b0;
    cap_cyc   = 1'b0;
    we_d      = 1'b0;
    wdata_d   = in_data;
    confirm   = 1'b0;
    flush     = 1'b0;
    ack_v_d   = 1'b0;
    ack_c_d   = CODE_DONE;
    ack_s_d   = send_q;
    cyc_v_d   = 1'b0;
    crc_seed  = 1'b0;
    crc_start = 1'b0;
    crc_upd   = 1'b0;

    if (in_valid && in_sop) begin
      hdr_load = 1'b1;
      flush    = pend_q;
      pend_d   = 1'b0;
      cnt_d    = LEN_W'(1);
      if (am_cycst) begin
        crc_start = 1'b1;
        st_d      = ST_HDR;
      end else if (am_accept) begin
        if (need > NW'(ptr_free)) begin
          ack_v_d = 1'b1;
          ack_c_d = CODE_BUSY;
          ack_s_d = am_send;
          st_d    = ST_SKIP;
        end else begin
          we_d      = 1'b1;
          pend_d    = 1'b1;
          crc_start = 1'b1;
          st_d      = ST_HDR;
        end
      end else begin
        st_d = ST_SKIP;
      end
    end else if (in_valid) begin
      unique case (st_q)
        ST_HDR: begin
          crc_upd = 1'b1;
          we_d    = store_q;
          cap_cyc = (cnt_q == LEN_W'(1));
          cnt_d   = cnt_q + LEN_W'(1);
          if (cnt_q == HDR_LAST) st_d = ST_HCRC;
        end
        ST_HCRC: begin
          st_d   = ST_SKIP;
          pend_d = 1'b0;
          if (in_data == crc_cur) begin
            if (!store_q) begin
              cyc_v_d = 1'b1;
            end else begin
              confirm = 1'b1;
              if (haspay_q) begin
                crc_seed = 1'b1;
                cnt_d    = '0;
                st_d     = ST_PAY;
              end else begin
                we_d    = 1'b1;
                wdata_d = status_word(tc_q, CODE_DONE);
                ack_v_d = 1'b1;
              end
            end
          end else begin
            flush = store_q;
          end
        end
        ST_PAY: begin
          we_d    = 1'b1;
          confirm = 1'b1;
          crc_upd = 1'b1;
          cnt_d   = cnt_q + LEN_W'(1);
          if (cnt_q == len_q - LEN_W'(1)) st_d = ST_DCRC;
        end
        ST_DCRC: begin
          we_d    = 1'b1;
          confirm = 1'b1;
          wdata_d = status_word(tc_q, dcode);
          ack_v_d = 1'b1;
          ack_c_d = dcode;
          st_d    = ST_SKIP;
        end
        default: begin
          st_d = ST_SKIP;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q         <= ST_SKIP;
      cnt_q        <= '0;
      pend_q       <= 1'b0;
      tc_q         <= '0;
      store_q      <= 1'b0;
      send_q       <= 1'b0;
      haspay_q     <= 1'b0;
      len_q        <= '0;
      cyc_hold_q   <= '0;
      we_q         <= 1'b0;
      waddr_q      <= '0;
      wdata_q      <= '0;
      ack_v_q      <= 1'b0;
      ack_c_q      <= '0;
      ack_s_q      <= 1'b0;
      cyc_v_q      <= 1'b0;
      cyc_time_q   <= '0;
      commit_out_q <= '0;
    end else begin
      st_q         <= st_d;
      cnt_q        <= cnt_d;
      pend_q       <= pend_d;
      we_q         <= we_d;
      ack_v_q      <= ack_v_d;
      cyc_v_q      <= cyc_v_d;
      commit_out_q <= ptr_commit;
      if (hdr_load) begin
        tc_q     <= in_data[3:0];
        store_q  <= !am_cycst;
        send_q   <= am_send;
        haspay_q <= am_haspay;
        len_q    <= in_data[LEN_LO+LEN_W-1:LEN_LO];
      end
      if (cap_cyc) cyc_hold_q <= in_data;
      if (we_d) begin
        waddr_q <= ptr_waddr;
        wdata_q <= wdata_d;
      end
      if (ack_v_d) begin
        ack_c_q <= ack_c_d;
        ack_s_q <= ack_s_d;
      end
      if (cyc_v_d) cyc_time_q <= cyc_hold_q;
    end
  end

  assign fifo_we         = we_q;
  assign fifo_waddr      = waddr_q;
  assign fifo_wdata      = wdata_q;
  assign fifo_commit_ptr = commit_out_q;
  assign ack_valid       = ack_v_q;
  assign ack_code        = ack_c_q;
  assign ack_send        = ack_s_q;
  assign cyc_valid       = cyc_v_q;
  assign cyc_time        = cyc_time_q;

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_SKIP && !(in_valid && in_sop)) |=> !fifo_we); // R1
  AST_PAY_WRITTEN: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_PAY && in_valid && !in_sop) |=> fifo_we); // R4
  AST_ACK_LEGAL: assert property (@(posedge clk) disable iff (!srst_n)
    ack_valid |-> (ack_code == CODE_DONE || ack_code == CODE_DERR || ack_code == CODE_BUSY)); // R6
  AST_CYC_NOT_STORED: assert property (@(posedge clk) disable iff (!srst_n)
    (!store_q && st_q != ST_SKIP && in_valid && !in_sop) |=> !fifo_we); // R7
  AST_CYC_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    cyc_valid |=> !cyc_valid); // R7
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_valid && ack_code == CODE_BUSY) |-> !fifo_we); // R8
endmodule

// File: tb/lpr_filter_bench.sv
`timescale 1ns/1ps
module lpr_filter_bench;
  localparam int AW    = 5;
  localparam int DEPTH = 32;
  localparam int HDR_Q = 2;
  localparam logic [5:0]  NODE = 6'd5;
  localparam logic [63:0] CHMASK = 64'h0000_0000_0000_0410; // channels 4 and 10

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic        rst_n;
  logic        in_valid, in_sop;
  logic [31:0] in_data;
  logic [AW:0] rd_ptr;
  logic        fifo_we;
  logic [AW-1:0] fifo_waddr;
  logic [31:0] fifo_wdata;
  logic [AW:0] fifo_commit_ptr;
  logic        ack_valid, ack_send, cyc_valid;
  logic [3:0]  ack_code;
  logic [31:0] cyc_time;

  lpr_filter u_lpr_filter (
    .clk(clk), .rst_n(rst_n), .node_id(NODE), .chan_en(CHMASK),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .fifo_rd_ptr(rd_ptr), .fifo_we(fifo_we), .fifo_waddr(fifo_waddr),
    .fifo_wdata(fifo_wdata), .fifo_commit_ptr(fifo_commit_ptr),
    .ack_valid(ack_valid), .ack_code(ack_code), .ack_send(ack_send),
    .cyc_valid(cyc_valid), .cyc_time(cyc_time)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] mem [DEPTH];
  logic [31:0] exp_q[$];
  string       exp_tag[$];
  logic [4:0]  ack_q[$];

  always @(posedge clk) if (fifo_we) mem[fifo_waddr] <= fifo_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // R10 reference: 0x04C11DB7, all-ones preset, msb first, no reflection
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 32; b++) begin
      fb = r[31] ^ d[31-b];
      r  = r << 1;
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_valid) begin
        if (ack_q.size() == 0) chk(1'b0, "R6 unexpected ack", {27'b0, ack_send, ack_code}, 32'h0);
        else begin
          logic [4:0] e;
          e = ack_q.pop_front();
          chk({ack_send, ack_code} == e, "R6 ack code/send", {27'b0, ack_send, ack_code}, {27'b0, e});
        end
      end
      if (fifo_commit_ptr != rd_ptr) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected committed quadlet", mem[rd_ptr[AW-1:0]], 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          chk(mem[rd_ptr[AW-1:0]] == e, t, mem[rd_ptr[AW-1:0]], e);
        end
        rd_ptr = rd_ptr + 1'b1;
      end
    end
  end

  task automatic send_pkt(input logic [5:0] dest, input logic [5:0] ch, input logic [3:0] tc,
                          input int len, input logic [31:0] h1, input bit bad_h,
                          input bit bad_d, input bit gaps);
    logic [31:0] pk[$];
    logic [31:0] q0, c, pw;
    bit acc, haspay, send, exp_cyc;
    int need;
    logic [3:0] code;
    q0 = {dest, ch, 4'h0, len[7:0], 4'h0, tc};
    pk.push_back(q0);
    pk.push_back(h1);
    c = ref_crc(ref_crc(32'hFFFF_FFFF, q0), h1);
    pk.push_back(bad_h ? (c ^ 32'h1) : c);
    haspay = (tc == 4'h1 || tc == 4'hA) && len != 0;
    c = 32'hFFFF_FFFF;
    if (haspay) begin
      for (int i = 0; i < len; i++) begin
        pw = (32'h0101_0101 * (i + 1)) ^ h1;
        pk.push_back(pw);
        c = ref_crc(c, pw);
      end
      pk.push_back(bad_d ? ~c : c);
    end
    // expectations from R1, R5, R6, R8
    acc  = ((tc == 4'h0 || tc == 4'h1) && (dest == NODE || dest == 6'h3F)) ||
           (tc == 4'hA && CHMASK[ch]);
    send = (tc == 4'h0 || tc == 4'h1) && dest == NODE && dest != 6'h3F;
    exp_cyc = (tc == 4'h8) && !bad_h;
    need = HDR_Q + (haspay ? len : 0) + 1;
    if (tc != 4'h8 && acc) begin
      if (need > DEPTH) ack_q.push_back({send, 4'h4});
      else if (!bad_h) begin
        exp_q.push_back(q0); exp_tag.push_back("R2 header quadlet 0");
        exp_q.push_back(h1); exp_tag.push_back("R2 header quadlet 1");
        if (haspay)
          for (int i = 3; i < 3 + len; i++) begin
            exp_q.push_back(pk[i]); exp_tag.push_back("R4 payload quadlet");
          end
        code = (haspay && bad_d) ? 4'hD : 4'h1;
        exp_q.push_back({24'h0, tc, code}); exp_tag.push_back("R5 status quadlet");
        ack_q.push_back({send, code});
      end
    end
    foreach (pk[i]) begin
      @(negedge clk);
      if (gaps && i == 2) begin
        in_valid = 1'b0; in_sop = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_data  = pk[i];
    end
    @(negedge clk);
    chk(cyc_valid == exp_cyc && (!exp_cyc || cyc_time == h1), "R7 R11 cycle-start pulse",
        exp_cyc ? cyc_time : {31'b0, cyc_valid}, exp_cyc ? h1 : 32'h0);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = '0; rd_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!fifo_we && !ack_valid && !cyc_valid, "R12 outputs idle after reset",
        {29'b0, fifo_we, ack_valid, cyc_valid}, 32'h0);
    chk(fifo_commit_ptr == '0, "R12 committed pointer zero", {26'b0, fifo_commit_ptr}, 32'h0);

    send_pkt(NODE, 6'd0, 4'h0, 0, 32'h1111_0001, 0, 0, 0);   drain(); // R2 R5 header only
    send_pkt(NODE, 6'd0, 4'h1, 4, 32'h2222_0002, 0, 0, 1);   drain(); // R4 block, with gap
    send_pkt(NODE, 6'd0, 4'h1, 3, 32'h3333_0003, 0, 1, 0);   drain(); // R6 data error
    send_pkt(NODE, 6'd0, 4'h1, 2, 32'h4444_0004, 1, 0, 0);            // R3 bad header
    send_pkt(NODE, 6'd0, 4'h0, 0, 32'h4444_0005, 0, 0, 0);   drain(); // R3 rewind proven
    send_pkt(6'd9, 6'd0, 4'h1, 2, 32'h5555_0006, 0, 0, 0);   drain(); // R1 other node
    send_pkt(6'h3F, 6'd0, 4'h1, 2, 32'h6666_0007, 0, 0, 0);  drain(); // R1 R6 broadcast
    send_pkt(6'd1, 6'd10, 4'hA, 3, 32'h7777_0008, 0, 1, 0);  drain(); // R6 iso data error
    send_pkt(6'd1, 6'd11, 4'hA, 3, 32'h7777_0009, 0, 0, 0);  drain(); // R1 channel off
    send_pkt(NODE, 6'd0, 4'h3, 0, 32'h8888_000A, 0, 0, 0);   drain(); // R1 unknown type
    send_pkt(6'h3F, 6'd0, 4'h8, 0, 32'h0ABC_DEF1, 0, 0, 0);  drain(); // R7 cycle-start
    send_pkt(6'h3F, 6'd0, 4'h8, 0, 32'h0ABC_DEF2, 1, 0, 0);  drain(); // R7 bad crc, no pulse
    send_pkt(NODE, 6'd0, 4'h1, 30, 32'h9999_000B, 0, 0, 0);  drain(); // R8 busy
    send_pkt(NODE, 6'd0, 4'h1, 29, 32'h9999_000C, 0, 0, 0);  drain(); // R8 exact fit
    // R9: abandon after first quadlet
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b1;
    in_data = {NODE, 6'd0, 4'h0, 8'd3, 4'h0, 4'h1};
    send_pkt(NODE, 6'd0, 4'h0, 0, 32'hAAAA_000D, 0, 0, 0);   drain();
    // R9: abandon just before the header CRC quadlet
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b1;
    in_data = {NODE, 6'd0, 4'h0, 8'd0, 4'h0, 4'h0};
    @(negedge clk); in_sop = 1'b0; in_data = 32'hDEAD_0000;
    send_pkt(6'h3F, 6'd0, 4'h1, 1, 32'hAAAA_000E, 0, 0, 0);  drain();

    chk(exp_q.size() == 0, "R5 all expected quadlets committed", exp_q.size(), 32'h0);
    chk(ack_q.size() == 0, "R6 all expected codes reported", ack_q.size(), 32'h0);
    chk(fifo_commit_ptr == rd_ptr, "R2 nothing left uncommitted-visible",
        {26'b0, fifo_commit_ptr}, {26'b0, rd_ptr});
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule